// File: doc/BRIEF.md
# Segmented Byte-Lane Memory Access Unit

This unit sits between a requester that thinks in segment and offset pairs and a byte-addressed memory bus. The memory bus has a 20-bit address and a 16-bit data path split into two byte lanes. For each accepted request it forms the physical address by shifting the segment left four places and adding the offset. It then runs one or two bus cycles and steers the bytes onto the correct lanes.

Bytes at even addresses use the low lane, and bytes at odd addresses use the high lane. A word that starts at an even address moves in a single cycle. A word that starts at an odd address is split into two byte cycles, and the read result is reassembled with the lower address holding the least significant byte.

The requester uses a valid/ready handshake. The unit finishes each request with a one-cycle response pulse, which carries the read data for a read. The bus side has no wait states: each bus cycle lasts one clock, and read data is sampled at the end of that cycle.

The controller is a four-state machine:

- **IDLE**: ready is high. When a request is accepted, the unit moves to FIRST.
- **FIRST**: the first or only bus cycle. It moves to SECOND for an odd-address word, and to RESP for any other request.
- **SECOND**: the high-byte cycle of a split word. It always moves to RESP.
- **RESP**: the response pulse. It always moves back to IDLE.

Top module: `seg_lane_mau`

## Requirements
- R1: In the first bus cycle of a request, `bus_addr` equals (segment × 16 + offset) modulo 2^20. Any carry out of bit 19 is dropped, and bit 0 of `bus_addr` is the A0 line.
- R2: An even-address word runs exactly one bus cycle with `bhe_n`=0 and A0=0. A write drives all 16 bits of write data unchanged.
- R3: An even-address byte runs exactly one bus cycle with `bhe_n`=1 and A0=0. A write drives the byte on bits 7:0 and drives bits 15:8 to zero.
- R4: An odd-address byte runs exactly one bus cycle with `bhe_n`=0 and A0=1. A write drives the byte on bits 15:8 and drives bits 7:0 to zero.
- R5: An odd-address word N runs two back-to-back bus cycles:
  - The first cycle is at N with `bhe_n`=0. A write carries data bits 7:0 on lane bits 15:8, with the low lane driven to zero.
  - The second cycle is at (N+1) modulo 2^20 with `bhe_n`=1. A write carries data bits 15:8 on lane bits 7:0, with the high lane driven to zero.
- R6: A word read returns the byte from the lower address in bits 7:0 and the byte from the next address in bits 15:8. A byte read returns the byte from its own lane in bits 7:0, with bits 15:8 zero.
- R7: `req_ready` is high only when no request is in progress. `rsp_valid` is a single-cycle pulse in the clock after the last bus cycle, and `req_ready` stays low from acceptance through that pulse.
- R8: In every bus cycle exactly one strobe is low: `rd_n` for a read and `wr_n` for a write. Outside bus cycles both strobes and `bhe_n` are high, and `bus_wdata` is zero.
- R9: After reset the unit is idle: `req_ready`=1, `rsp_valid`=0, and `rd_n`, `wr_n` and `bhe_n` are all 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within segment |
| req_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Assembled read data, valid with `rsp_valid` on reads |
| bus_addr | output | 20 | Physical byte address; bit 0 is A0 |
| bhe_n | output | 1 | High-lane enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from memory, sampled at the end of a read cycle |

## Verification
A state register that picks the wrong transfer kind shows up in the first bus cycle, one clock after acceptance. It appears as a wrong `bhe_n`, a misplaced write byte, or a missing or extra second cycle. A fault in the address adder or in the second-cycle increment appears on `bus_addr` in that same cycle, including the case where the address wraps from FFFFFh to 00000h. A read-merge fault stays hidden until the response pulse, two or three clocks after acceptance, where it shows as swapped or unzeroed bytes in `rsp_rdata`.

// File: rtl/seg_lane_pkg.sv
package seg_lane_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_RESP
    } mau_state_e;

    typedef enum logic [1:0] {
        XF_EVEN_WORD,
        XF_EVEN_BYTE,
        XF_ODD_BYTE,
        XF_ODD_WORD
    } xfer_kind_e;

    function automatic xfer_kind_e classify(input logic is_word, input logic odd);
        if (is_word) return odd ? XF_ODD_WORD : XF_EVEN_WORD;
        return odd ? XF_ODD_BYTE : XF_EVEN_BYTE;
    endfunction

endpackage

// File: rtl/seg_lane_addr.sv
module seg_lane_addr #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [SEG_W-1:0]           seg,
    input  logic [OFF_W-1:0]           off,
    output logic [SEG_W+SEG_SHIFT-1:0] phys
);
    localparam int ADDR_W = SEG_W + SEG_SHIFT;

    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] off_ext;

    // Only the low ADDR_W bits of the sum are kept, so any carry out of the top bit is dropped.
    always_comb begin
        seg_base = {seg, {SEG_SHIFT{1'b0}}};
        off_ext  = {{(ADDR_W-OFF_W){1'b0}}, off};
        phys     = seg_base + off_ext;
    end
endmodule

// File: rtl/seg_lane_steer.sv
module seg_lane_steer
    import seg_lane_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  xfer_kind_e          kind,
    input  logic                second,
    input  logic [2*LANE_W-1:0] wdata,
    output logic                bhe_n,
    output logic [2*LANE_W-1:0] lane_data
);
    localparam int DATA_W = 2 * LANE_W;
    localparam logic [LANE_W-1:0] ZL = '0;

    always_comb begin
        bhe_n     = 1'b1;
        lane_data = '0;
        unique case (kind)
            XF_EVEN_WORD: begin
                bhe_n     = 1'b0;
                lane_data = wdata;
            end
            XF_EVEN_BYTE: begin
                lane_data = {ZL, wdata[LANE_W-1:0]};
            end
            XF_ODD_BYTE: begin
                bhe_n     = 1'b0;
                lane_data = {wdata[LANE_W-1:0], ZL};
            end
            XF_ODD_WORD: begin
                if (second) begin
                    lane_data = {ZL, wdata[DATA_W-1:LANE_W]};
                end else begin
                    bhe_n     = 1'b0;
                    lane_data = {wdata[LANE_W-1:0], ZL};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_lane_merge.sv
module seg_lane_merge
    import seg_lane_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  xfer_kind_e          kind,
    input  logic                second,
    input  logic [2*LANE_W-1:0] bus_rdata,
    input  logic [2*LANE_W-1:0] held,
    output logic [2*LANE_W-1:0] merged
);
    localparam int DATA_W = 2 * LANE_W;
    localparam logic [LANE_W-1:0] ZL = '0;

    always_comb begin
        merged = held;
        unique case (kind)
            XF_EVEN_WORD: merged = bus_rdata;
            XF_EVEN_BYTE: merged = {ZL, bus_rdata[LANE_W-1:0]};
            XF_ODD_BYTE:  merged = {ZL, bus_rdata[DATA_W-1:LANE_W]};
            XF_ODD_WORD: begin
                if (second) merged = {bus_rdata[LANE_W-1:0], held[LANE_W-1:0]};
                else        merged = {held[DATA_W-1:LANE_W], bus_rdata[DATA_W-1:LANE_W]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_lane_mau.sv
module seg_lane_mau
    import seg_lane_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int LANE_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [SEG_W-1:0]              req_seg,
    input  logic [OFF_W-1:0]              req_off,
    input  logic                          req_word,
    input  logic                          req_write,
    input  logic [2*LANE_W-1:0]           req_wdata,
    output logic                          rsp_valid,
    output logic [2*LANE_W-1:0]           rsp_rdata,
    output logic [SEG_W+SEG_SHIFT-1:0]    bus_addr,
    output logic                          bhe_n,
    output logic                          rd_n,
    output logic                          wr_n,
    output logic [2*LANE_W-1:0]           bus_wdata,
    input  logic [2*LANE_W-1:0]           bus_rdata
);
    localparam int ADDR_W = SEG_W + SEG_SHIFT;
    localparam int DATA_W = 2 * LANE_W;

    mau_state_e        state_q, state_d;
    xfer_kind_e        kind_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ADDR_W-1:0] phys_q;
    logic [ADDR_W-1:0] phys_inc;
    logic [ADDR_W-1:0] phys_d;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] lane_data;
    logic              lane_bhe_n;
    logic              in_cycle;
    logic              second;
    logic              accept;

    seg_lane_addr #(
        .SEG_W     (SEG_W),
        .OFF_W     (OFF_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) addr_i (
        .seg  (req_seg),
        .off  (req_off),
        .phys (phys_d)
    );

    seg_lane_steer #(.LANE_W(LANE_W)) steer_i (
        .kind      (kind_q),
        .second    (second),
        .wdata     (wdata_q),
        .bhe_n     (lane_bhe_n),
        .lane_data (lane_data)
    );

    seg_lane_merge #(.LANE_W(LANE_W)) merge_i (
        .kind      (kind_q),
        .second    (second),
        .bus_rdata (bus_rdata),
        .held      (rdata_q),
        .merged    (merged)
    );

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign in_cycle = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign second   = (state_q == ST_SECOND);
    assign phys_inc = phys_q + ADDR_W'(1);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FIRST;
            ST_FIRST:  state_d = (kind_q == XF_ODD_WORD) ? ST_SECOND : ST_RESP;
            ST_SECOND: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= XF_EVEN_WORD;
            write_q <= 1'b0;
            wdata_q <= '0;
            phys_q  <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q  <= classify(req_word, phys_d[0]);
                write_q <= req_write;
                wdata_q <= req_wdata;
                phys_q  <= phys_d;
            end
            if (in_cycle && !write_q) rdata_q <= merged;
        end
    end

    // Outputs.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_rdata = rdata_q;
        bus_addr  = '0;
        bhe_n     = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        bus_wdata = '0;
        if (in_cycle) begin
            bus_addr = second ? phys_inc : phys_q;
            bhe_n    = lane_bhe_n;
            rd_n     = write_q;
            wr_n     = !write_q;
            if (write_q) bus_wdata = lane_data;
        end
    end
endmodule

// File: rtl/seg_lane_mau_chk.sv
module seg_lane_mau_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bhe_n,
    input logic              rd_n,
    input logic              wr_n
);
    logic cyc;
    assign cyc = !rd_n || !wr_n;

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_quiet_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc |-> bhe_n);

    assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cyc && !rsp_valid));

    assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_rsp_after_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cyc));

    assert_odd_high_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && bus_addr[0]) |-> !bhe_n);

    assert_split_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc && $past(cyc)) |-> ((bus_addr == ADDR_W'($past(bus_addr) + 1'b1)) && bhe_n));
endmodule

bind seg_lane_mau seg_lane_mau_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_addr  (bus_addr),
    .bhe_n     (bhe_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/seg_lane_mau_tb_top.sv
`timescale 1ns/1ps
module seg_lane_mau_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_seg = '0;
    logic [15:0] req_off = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] bus_addr;
    logic        bhe_n;
    logic        rd_n;
    logic        wr_n;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    seg_lane_mau dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_seg   (req_seg),
        .req_off   (req_off),
        .req_word  (req_word),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .bus_addr  (bus_addr),
        .bhe_n     (bhe_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [7:0] mem_b(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
    endfunction

    function automatic logic [15:0] mem_lanes(input logic [19:0] a);
        logic [19:0] ev;
        ev = a & 20'hFFFFE;
        return {mem_b(ev | 20'h1), mem_b(ev)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic run_req(input logic [15:0] s, input logic [15:0] o,
                           input logic w, input logic wr);
        logic [19:0] p;
        logic [19:0] p1;
        logic        odd;
        logic        split;
        logic [15:0] wd;
        logic [15:0] exp_rd;
        logic [15:0] exp_wd;
        string       tag;
        p     = 20'({s, 4'h0} + {4'h0, o});
        p1    = 20'(p + 20'h1);
        odd   = p[0];
        split = w && odd;
        wd    = {s[7:0] ^ o[15:8], o[7:0] ^ 8'hA5};
        if (w && !odd)      tag = "R2";
        else if (!w && !odd) tag = "R3";
        else if (!w)        tag = "R4";
        else                tag = "R5";

        while (!req_ready) @(negedge clk);
        req_seg   = s;
        req_off   = o;
        req_word  = w;
        req_write = wr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;

        // First (or only) bus cycle
        chk("R1 addr", bus_addr, p);
        chk({tag, " bhe_n"}, bhe_n, !(odd || w));
        chk({tag, " A0"}, bus_addr[0], odd);
        chk("R8 strobes", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
        chk("R7 ready busy", req_ready, 1'b0);
        chk("R7 no early rsp", rsp_valid, 1'b0);
        if (wr) begin
            if (w && !odd) exp_wd = wd;
            else if (!odd) exp_wd = {8'h00, wd[7:0]};
            else           exp_wd = {wd[7:0], 8'h00};
            chk({tag, " wdata"}, bus_wdata, exp_wd);
        end
        bus_rdata = mem_lanes(p);
        @(negedge clk);

        if (split) begin
            chk("R5 second addr", bus_addr, p1);
            chk("R5 second bhe_n", bhe_n, 1'b1);
            chk("R8 strobes 2nd", {rd_n, wr_n}, wr ? 2'b10 : 2'b01);
            chk("R7 no early rsp 2nd", rsp_valid, 1'b0);
            if (wr) chk("R5 second wdata", bus_wdata, {8'h00, wd[15:8]});
            bus_rdata = mem_lanes(p1);
            @(negedge clk);
        end

        // Response cycle
        chk({tag, " rsp_valid R7"}, rsp_valid, 1'b1);
        chk("R8 idle strobes", {rd_n, wr_n, bhe_n}, 3'b111);
        chk("R8 idle wdata", bus_wdata, 16'h0000);
        if (!wr) begin
            exp_rd = w ? {mem_b(p1), mem_b(p)} : {8'h00, mem_b(p)};
            chk({tag, " R6 rdata"}, rsp_rdata, exp_rd);
        end
        @(negedge clk);
        chk("R7 pulse ends", rsp_valid, 1'b0);
    endtask

    initial begin
        logic [15:0] segs [6];
        logic [15:0] bases [3];
        segs[0]  = 16'h0000; segs[1] = 16'h0001; segs[2] = 16'hFFFF;
        segs[3]  = 16'hF000; segs[4] = 16'h1234; segs[5] = 16'hFFFE;
        bases[0] = 16'h0000; bases[1] = 16'hFFF0; bases[2] = 16'h8000;

        repeat (3) @(negedge clk);
        chk("R9 reset ready", req_ready, 1'b1);
        chk("R9 reset rsp", rsp_valid, 1'b0);
        chk("R9 reset strobes", {rd_n, wr_n, bhe_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", {req_ready, rd_n, wr_n, bhe_n, rsp_valid}, 5'b11110);

        // Carry wraps: FFFF0 + 000F = FFFFF, and the odd word's second cycle is at 00000
        run_req(16'hFFFF, 16'h000F, 1'b1, 1'b0);
        run_req(16'hFFFF, 16'h000F, 1'b1, 1'b1);

        for (int si = 0; si < 6; si++)
            for (int bi = 0; bi < 3; bi++)
                for (int lo = 0; lo < 16; lo++)
                    for (int m = 0; m < 4; m++)
                        run_req(segs[si], bases[bi] | 16'(lo), m[0], m[1]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 60000 && !done) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
                $finish;
            end
        end
    end

endmodule